// File: doc/BRIEF.md
# Bus Abort Status Capture

This block sits beside the system bus and keeps a diagnostic record of the latest access that faulted. Logic elsewhere decides whether an access is illegal and raises one or more cause strobes for the current transfer: undefined target, misaligned address, or protection violation. In that same cycle the block drives an abort pulse to every bus master, whichever master issued the transfer. On the next clock edge it records the full address, the access size, the access kind, a single cause and the issuing master.

Beside this last-fault record, the block keeps one sticky flag per master. The flags show which masters have aborted since software last read the status word. Software reads the address word or the status word through a small read port. Reading the status word clears the sticky flags. An abort that lands in the same cycle as that read still leaves its own flag set.

Top module: `abort_status_capture`

## Requirements
- R1: After reset the address word and the status word both read as zero, and abortOut is low.
- R2: In any cycle where at least one of faultUndef, faultMisalign or faultProt is high, every bit of abortOut is high in that same cycle. Every bit is low in cycles with no cause strobe.
- R3: On an abort, the address word (rdAddr=0) takes the value of faultAddr on the next edge. It keeps that value through cycles with no abort.
- R4: On an abort, status bits [1:0] take faultSize (0 byte, 1 halfword, 2 word) and bits [3:2] take faultType (0 data read, 1 data write, 2 instruction fetch).
- R5: Status bits [6:4] hold one cause, one-hot: bit 4 undefined address, bit 5 misaligned, bit 6 protection. When several strobes are high together, undefined wins over misaligned, and misaligned wins over protection.
- R6: Status bits [9:8] hold the last aborting master, one-hot: bit 8 is master 0 and bit 9 is master 1. Each abort overwrites them.
- R7: Sticky bits [11:10] (bit 10 master 0, bit 11 master 1) are set by an abort from master m only if source bit m was clear before that abort. Otherwise they are left as they were.
- R8: A status read (rdEn=1, rdAddr=1) returns the word as it stood before the read and clears both sticky bits on that edge. An address read clears nothing.
- R9: When an abort and a status read fall in the same cycle, the abort's sticky rule from R7 is applied after the clear. Its flag can therefore end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultUndef | input | 1 | Current transfer targets an undefined address |
| faultMisalign | input | 1 | Current transfer is misaligned |
| faultProt | input | 1 | Current transfer violates protection |
| faultAddr | input | 32 | Address of the current transfer |
| faultSize | input | 2 | Size code of the current transfer |
| faultType | input | 2 | Kind of the current transfer |
| faultMaster | input | 1 | Index of the master issuing the current transfer |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 1 | 0 selects the address word, 1 the status word |
| rdData | output | 32 | Read data, combinational, zero when rdEn is low |
| abortOut | output | 2 | Abort pulse broadcast to each master |

## Verification
The assertions assume that the fault address, size, type and master inputs are settled whenever any cause strobe is high. They also assume that the cause strobes are single-cycle events tied to one transfer. The stimulus drives all of these inputs together, shortly after a rising edge, and holds them for exactly one cycle. It returns the strobes to zero between events. Reads are issued only as one-cycle strobes on the same timing, so a status read and an abort share a cycle only when a test sets that up on purpose.

// File: rtl/abort_status_pkg.sv
package abort_status_pkg;

  // Status word field positions (software decodes these)
  localparam int SizeLsb  = 0;
  localparam int TypeLsb  = 2;
  localparam int CauseLsb = 4;
  localparam int SrcLsb   = 8;

  // Cause bit indices inside the one-hot cause field
  localparam int CauseUndefIdx    = 0;
  localparam int CauseMisalignIdx = 1;
  localparam int CauseProtIdx     = 2;
  localparam int CauseWidth       = 3;

  typedef enum logic [1:0] {
    ACC_DATA_READ  = 2'd0,
    ACC_DATA_WRITE = 2'd1,
    ACC_FETCH      = 2'd2
  } acc_kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                  capture;
    logic                  clearSticky;
    logic                  stickyArm;
    logic [CauseWidth-1:0] causeOneHot;
  } strobe_t;

endpackage

// File: rtl/abort_status_ctrl.sv
module abort_status_ctrl
  import abort_status_pkg::*;
#(
  parameter int NumMasters = 2,
  localparam int MasterIdW = (NumMasters > 1) ? $clog2(NumMasters) : 1
) (
  input  logic                  faultUndef,
  input  logic                  faultMisalign,
  input  logic                  faultProt,
  input  logic [MasterIdW-1:0]  faultMaster,
  input  logic [NumMasters-1:0] srcQ,
  input  logic                  rdEn,
  input  logic                  rdAddr,
  output strobe_t               strobes,
  output logic [NumMasters-1:0] abortOut
);

  logic anyCause;
  logic [CauseWidth-1:0] causePick;

  assign anyCause = faultUndef | faultMisalign | faultProt;

  // Fixed priority: undefined, then misaligned, then protection
  always_comb begin
    causePick = '0;
    if (faultUndef)         causePick[CauseUndefIdx]    = 1'b1;
    else if (faultMisalign) causePick[CauseMisalignIdx] = 1'b1;
    else if (faultProt)     causePick[CauseProtIdx]     = 1'b1;
  end

  always_comb begin
    strobes.capture     = anyCause;
    strobes.clearSticky = rdEn & rdAddr;
    strobes.stickyArm   = anyCause & ~srcQ[faultMaster];
    strobes.causeOneHot = causePick;
  end

  // Broadcast to every master
  for (genvar m = 0; m < NumMasters; m++) begin : g_bcast
    assign abortOut[m] = anyCause;
  end

endmodule

// File: rtl/abort_status_datapath.sv
module abort_status_datapath
  import abort_status_pkg::*;
#(
  parameter int AddrWidth  = 32,
  parameter int RegWidth   = 32,
  parameter int NumMasters = 2,
  localparam int MasterIdW = (NumMasters > 1) ? $clog2(NumMasters) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobes,
  input  logic [AddrWidth-1:0]  faultAddr,
  input  logic [1:0]            faultSize,
  input  logic [1:0]            faultType,
  input  logic [MasterIdW-1:0]  faultMaster,
  input  logic                  rdEn,
  input  logic                  rdAddr,
  output logic [RegWidth-1:0]   rdData,
  output logic [AddrWidth-1:0]  addrQ,
  output logic [CauseWidth-1:0] causeQ,
  output logic [NumMasters-1:0] srcQ,
  output logic [NumMasters-1:0] stickyQ
);

  localparam int StickyLsb = SrcLsb + NumMasters;

  logic [1:0] sizeQ;
  logic [1:0] typeQ;
  logic [RegWidth-1:0] statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizeQ  <= '0;
      typeQ  <= '0;
      causeQ <= '0;
      srcQ   <= '0;
    end else if (strobes.capture) begin
      addrQ  <= faultAddr;
      sizeQ  <= faultSize;
      typeQ  <= faultType;
      causeQ <= strobes.causeOneHot;
      srcQ   <= NumMasters'(1) << faultMaster;
    end
  end

  // Per-master sticky flags; a set outranks the read clear
  for (genvar m = 0; m < NumMasters; m++) begin : g_sticky
    logic setHere;
    assign setHere = strobes.stickyArm && (faultMaster == MasterIdW'(m));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    stickyQ[m] <= 1'b0;
      else if (setHere)             stickyQ[m] <= 1'b1;
      else if (strobes.clearSticky) stickyQ[m] <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[SizeLsb +: 2]           = sizeQ;
    statusWord[TypeLsb +: 2]           = typeQ;
    statusWord[CauseLsb +: CauseWidth] = causeQ;
    statusWord[SrcLsb +: NumMasters]   = srcQ;
    statusWord[StickyLsb +: NumMasters] = stickyQ;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (rdAddr) rdData = statusWord;
      else        rdData[AddrWidth-1:0] = addrQ;
    end
  end

endmodule

// File: rtl/abort_status_capture.sv
module abort_status_capture
  import abort_status_pkg::*;
#(
  parameter int AddrWidth  = 32,
  parameter int RegWidth   = 32,
  parameter int NumMasters = 2,
  localparam int MasterIdW = (NumMasters > 1) ? $clog2(NumMasters) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  faultUndef,
  input  logic                  faultMisalign,
  input  logic                  faultProt,
  input  logic [AddrWidth-1:0]  faultAddr,
  input  logic [1:0]            faultSize,
  input  logic [1:0]            faultType,
  input  logic [MasterIdW-1:0]  faultMaster,
  input  logic                  rdEn,
  input  logic                  rdAddr,
  output logic [RegWidth-1:0]   rdData,
  output logic [NumMasters-1:0] abortOut
);

  strobe_t strobes;
  logic [AddrWidth-1:0]  addrQ;
  logic [CauseWidth-1:0] causeQ;
  logic [NumMasters-1:0] srcQ;
  logic [NumMasters-1:0] stickyQ;

  abort_status_ctrl #(.NumMasters(NumMasters)) u_ctrl (
    .faultUndef(faultUndef), .faultMisalign(faultMisalign), .faultProt(faultProt),
    .faultMaster(faultMaster), .srcQ(srcQ), .rdEn(rdEn), .rdAddr(rdAddr),
    .strobes(strobes), .abortOut(abortOut)
  );

  abort_status_datapath #(
    .AddrWidth(AddrWidth), .RegWidth(RegWidth), .NumMasters(NumMasters)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .faultAddr(faultAddr),
    .faultSize(faultSize), .faultType(faultType), .faultMaster(faultMaster),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .addrQ(addrQ),
    .causeQ(causeQ), .srcQ(srcQ), .stickyQ(stickyQ)
  );

endmodule

// File: rtl/abort_status_checker.sv
module abort_status_checker #(
  parameter int AddrWidth  = 32,
  parameter int NumMasters = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  faultUndef,
  input logic                  faultMisalign,
  input logic                  faultProt,
  input logic [AddrWidth-1:0]  faultAddr,
  input logic                  rdEn,
  input logic                  rdAddr,
  input logic [NumMasters-1:0] abortOut,
  input logic [AddrWidth-1:0]  addrQ,
  input logic [2:0]            causeQ,
  input logic [NumMasters-1:0] srcQ,
  input logic [NumMasters-1:0] stickyQ
);

  logic anyC;
  assign anyC = faultUndef | faultMisalign | faultProt;

  assert_abort_broadcast_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((&abortOut) || !(|abortOut)) && ((|abortOut) == anyC));

  assert_addr_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    anyC |=> addrQ == $past(faultAddr));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !anyC |=> $stable(addrQ));

  assert_cause_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    anyC |=> $onehot(causeQ));

  assert_cause_prio_R5: assert property (@(posedge clk) disable iff (!rstN)
    faultUndef |=> causeQ[0]);

  assert_src_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    anyC |=> $onehot(srcQ));

  assert_sticky_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    !anyC |=> (stickyQ & ~$past(stickyQ)) == '0);

  assert_sticky_keep_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && rdAddr) |=> (stickyQ & $past(stickyQ)) == $past(stickyQ));

endmodule

bind abort_status_capture abort_status_checker #(
  .AddrWidth(AddrWidth), .NumMasters(NumMasters)
) u_chk (
  .clk(clk), .rstN(rstN), .faultUndef(faultUndef), .faultMisalign(faultMisalign),
  .faultProt(faultProt), .faultAddr(faultAddr), .rdEn(rdEn), .rdAddr(rdAddr),
  .abortOut(abortOut), .addrQ(addrQ), .causeQ(causeQ), .srcQ(srcQ),
  .stickyQ(stickyQ)
);

// File: tb/abort_status_capture_bench.sv
`timescale 1ns/1ps
module abort_status_capture_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic faultUndef = 0, faultMisalign = 0, faultProt = 0;
  logic [31:0] faultAddr = '0;
  logic [1:0] faultSize = '0, faultType = '0;
  logic faultMaster = 1'b0;
  logic rdEn = 1'b0, rdAddr = 1'b0;
  logic [31:0] rdData;
  logic [1:0] abortOut;

  always #10 clk = ~clk;

  abort_status_capture u_abort_status_capture (
    .clk(clk), .rstN(rstN), .faultUndef(faultUndef), .faultMisalign(faultMisalign),
    .faultProt(faultProt), .faultAddr(faultAddr), .faultSize(faultSize),
    .faultType(faultType), .faultMaster(faultMaster), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData), .abortOut(abortOut)
  );

  typedef struct {
    logic        isRead;
    logic [31:0] data;
    logic        abort;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;

  // Reference model, built from the requirements
  logic [31:0] mAddr = '0;
  logic [1:0]  mSize = '0, mType = '0;
  logic [2:0]  mCause = '0;
  logic [1:0]  mSrc = '0, mSticky = '0;

  function automatic logic [31:0] statusWord();
    return {20'd0, mSticky, mSrc, 1'b0, mCause, mType, mSize};
  endfunction

  task automatic step(input logic u, input logic mis, input logic p,
                      input logic [31:0] a, input logic [1:0] sz,
                      input logic [1:0] ty, input logic mst,
                      input logic rd, input logic rs, input string tag);
    item_t it;
    @(posedge clk);
    #2;
    faultUndef = u; faultMisalign = mis; faultProt = p;
    faultAddr = a; faultSize = sz; faultType = ty; faultMaster = mst;
    rdEn = rd; rdAddr = rs;
    it.isRead = rd;
    it.data   = rd ? (rs ? statusWord() : mAddr) : 32'd0;
    it.abort  = u | mis | p;
    it.tag    = tag;
    q.push_back(it);
    if (rd && rs) mSticky = '0;
    if (u | mis | p) begin
      if (!mSrc[mst]) mSticky[mst] = 1'b1;
      mSrc  = 2'b01 << mst;
      mAddr = a; mSize = sz; mType = ty;
      mCause = u ? 3'b001 : (mis ? 3'b010 : 3'b100);
    end
  endtask

  task automatic idle(input logic rd, input logic rs, input string tag);
    step(0, 0, 0, 32'h0, 2'd0, 2'd0, 1'b0, rd, rs, tag);
  endtask

  // Monitor: pops one expected item per cycle and compares
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (abortOut !== {2{it.abort}}) begin
        fails++;
        $display("FAIL %s abortOut actual=%b expected=%b", it.tag, abortOut, {2{it.abort}});
      end
      if (it.isRead) begin
        checks++;
        if (rdData !== it.data) begin
          fails++;
          $display("FAIL %s rdData actual=%h expected=%h", it.tag, rdData, it.data);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    idle(1, 0, "R1 reset address");
    idle(1, 1, "R1 reset status");
    // First abort, master 0, undefined
    step(1, 0, 0, 32'hDEAD_BEE0, 2'd2, 2'd0, 1'b0, 0, 0, "R2 abort pulse undef");
    idle(1, 0, "R3 address capture");
    idle(1, 1, "R4 R5 R6 R7 status after first abort");
    idle(1, 1, "R8 sticky cleared by status read");
    idle(0, 0, "R2 no abort");
    idle(1, 0, "R3 address hold");
    // Master 0 again: misalign+prot, misalign wins; sticky0 not re-set
    step(0, 1, 1, 32'h1234_5671, 2'd1, 2'd1, 1'b0, 0, 0, "R2 abort pulse misalign");
    idle(1, 1, "R5 R7 priority and no re-arm");
    // Master 1 protection abort together with a status read
    step(0, 0, 1, 32'h0000_4000, 2'd0, 2'd2, 1'b1, 1, 1, "R9 read with abort");
    idle(1, 1, "R9 R6 sticky survives clear");
    idle(1, 0, "R8 address read keeps sticky");
    idle(1, 1, "R8 sticky still set after address read");
    // Master 1 again, all causes: undefined wins
    step(1, 1, 1, 32'hFFFF_FFFC, 2'd2, 2'd2, 1'b1, 0, 0, "R5 all causes");
    idle(1, 1, "R5 R7 undefined priority");
    // Mixed patterns
    for (int i = 0; i < 12; i++) begin
      logic [2:0] c;
      c = 3'((i * 5 + 1) % 8);
      step(c[0], c[1], c[2], 32'h8000_0000 ^ (i * 32'h0101_0103),
           2'(i % 3), 2'((i + 1) % 3), 1'(i / 3), 0, 0, "R2 pattern abort");
      idle(1, 0, "R3 pattern address");
      idle(1, (i % 2 == 0), "R4 R6 R7 R8 pattern status");
    end
    idle(0, 0, "R2 final idle");
    @(posedge clk);
    @(negedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule